// File: doc/BRIEF.md
# Programmable-Preset 16-bit CRC Engine

This block computes a 16-bit cyclic redundancy check over a stream of bytes presented by a host. The generator polynomial is x^16 + x^12 + x^5 + 1. The host first issues a start command together with a 2-bit selector. The command loads one of four starting values into the CRC register. The host then offers bytes one at a time with a valid strobe. Each accepted byte is folded into the register one bit per clock, so a byte occupies the engine for eight cycles. During those cycles the engine reports busy, and any byte offered in that time is dropped.

A per-byte order control picks which end of the byte enters first. With the control low, the engine uses the reflected form: it shifts right, uses the constant 8408h and takes bit 0 first. With the control high, it shifts left, uses the constant 1021h and takes bit 7 first. The order is captured when the byte is accepted. The running value is read out as a high byte and a low byte. No final inversion is applied.

Top module: `crc16_engine`

## Requirements
- R1: After reset the result is 0000h, busy_o is low and ready_o is high.
- R2: A clock edge with start_i high loads the value chosen by preset_sel_i into the register, and busy_o is low after that edge. The codes are 00 → 0000h, 01 → 6363h, 10 → A671h and 11 → FFFFh.
- R3: With msb_first_i low, each bit is taken from bit 0 upward. For each bit, the register shifts right and is XORed with 8408h when the bit differs from the old register bit 0. Preset 6363h followed by bytes 00h 00h gives 1EA0h.
- R4: With msb_first_i high, each bit is taken from bit 7 downward. For each bit, the register shifts left and is XORed with 1021h when the bit differs from the old register bit 15. Preset FFFFh over the ASCII string "123456789" gives 29B1h.
- R5: result_hi_o carries register bits 15:8 and result_lo_o carries bits 7:0. No final XOR is applied: preset FFFFh, order low, "123456789" reads 6F91h.
- R6: A byte is accepted on an edge where data_valid_i is high while busy_o and start_i are low. busy_o is then high for exactly the 8 following cycles. ready_o is always the inverse of busy_o.
- R7: A data_valid_i pulse while busy_o is high is ignored: neither the result nor the busy period changes.
- R8: start_i takes priority over data_valid_i on the same edge, and it aborts a byte in progress.
- R9: With busy_o, start_i and data_valid_i all low, the result holds its value.
- R10: The bit order is sampled when a byte is accepted. Changing msb_first_i while busy_o is high has no effect on that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the selected preset and abort any byte |
| preset_sel_i | input | 2 | Preset code used by start_i |
| msb_first_i | input | 1 | Bit order for the byte being accepted (1 = bit 7 first) |
| data_i | input | 8 | Byte to fold into the CRC |
| data_valid_i | input | 1 | data_i is offered this cycle |
| busy_o | output | 1 | Byte being processed |
| ready_o | output | 1 | Engine can accept a byte |
| result_hi_o | output | 8 | Upper byte of the CRC register |
| result_lo_o | output | 8 | Lower byte of the CRC register |

## Verification
The assertions assume that reset is applied before any stimulus. They also assume that start_i and data_valid_i are valid logic levels on every edge, and that the host decides whether a byte is accepted only from busy_o. The bench drives every input on the falling edge, so each input is stable for a full half-cycle around the rising edge. It deliberately drives valid during busy periods, starts that coincide with valid, and order changes in the middle of a byte. All of these stay within those assumptions and exercise the priority and drop rules.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W = 16;
  localparam int HALF_W = CRC_W / 2;

  typedef logic [CRC_W-1:0] crc_t;

  typedef enum logic [1:0] {
    PSEL_ZERO = 2'b00,
    PSEL_CARD = 2'b01,
    PSEL_ALT  = 2'b10,
    PSEL_ONES = 2'b11
  } psel_e;

  // Left-shifting update: the feedback comes from the top register bit.
  function automatic crc_t step_fwd(input crc_t c, input logic b, input crc_t poly);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Right-shifting (reflected) update: the feedback comes from register bit 0.
  function automatic crc_t step_rev(input crc_t c, input logic b, input crc_t poly);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[CRC_W-1:1]} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crc16_preset_sel.sv
module crc16_preset_sel
  import crc16_pkg::*;
#(
  parameter crc_t PRESET_0 = 16'h0000,
  parameter crc_t PRESET_1 = 16'h6363,
  parameter crc_t PRESET_2 = 16'hA671,
  parameter crc_t PRESET_3 = 16'hFFFF
) (
  input  logic [1:0] sel_i,
  output crc_t       value_o
);
  always_comb begin
    unique case (psel_e'(sel_i))
      PSEL_ZERO: value_o = PRESET_0;
      PSEL_CARD: value_o = PRESET_1;
      PSEL_ALT:  value_o = PRESET_2;
      default:   value_o = PRESET_3;
    endcase
  end
endmodule

// File: rtl/crc16_bit_step.sv
module crc16_bit_step
  import crc16_pkg::*;
#(
  parameter crc_t POLY_FWD = 16'h1021,
  parameter crc_t POLY_REV = 16'h8408
) (
  input  crc_t crc_i,
  input  logic bit_i,
  input  logic msb_first_i,
  output crc_t crc_o
);
  crc_t fwd_next;
  crc_t rev_next;

  assign fwd_next = step_fwd(crc_i, bit_i, POLY_FWD);
  assign rev_next = step_rev(crc_i, bit_i, POLY_REV);
  assign crc_o    = msb_first_i ? fwd_next : rev_next;
endmodule

// File: rtl/crc16_bit_seq.sv
module crc16_bit_seq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              msb_first_i,
  output logic              busy_o,
  output logic              bit_o,
  output logic              order_o,
  output logic              last_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              order_q;

  assign last_o  = busy_q && (cnt_q == LAST_IDX);
  assign bit_o   = order_q ? shreg_q[BYTE_W-1] : shreg_q[0];
  assign busy_o  = busy_q;
  assign order_o = order_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      order_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      shreg_q <= data_i;
      order_q <= msb_first_i;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      shreg_q <= order_q ? (shreg_q << 1) : (shreg_q >> 1);
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int   BYTE_W   = 8,
  parameter crc_t POLY_FWD = 16'h1021,
  parameter crc_t POLY_REV = 16'h8408,
  parameter crc_t PRESET_0 = 16'h0000,
  parameter crc_t PRESET_1 = 16'h6363,
  parameter crc_t PRESET_2 = 16'hA671,
  parameter crc_t PRESET_3 = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        preset_sel_i,
  input  logic              msb_first_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              data_valid_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [HALF_W-1:0] result_hi_o,
  output logic [HALF_W-1:0] result_lo_o
);
  crc_t crc_q;
  crc_t crc_next;
  crc_t preset_val;
  logic busy;
  logic cur_bit;
  logic cur_order;
  logic last_bit;

  // Named events, used by the checker.
  logic accept_evt;
  logic step_evt;
  logic load_evt;

  assign load_evt   = start_i;
  assign accept_evt = data_valid_i && !busy && !start_i;
  assign step_evt   = busy && !start_i;

  crc16_preset_sel #(
    .PRESET_0(PRESET_0), .PRESET_1(PRESET_1),
    .PRESET_2(PRESET_2), .PRESET_3(PRESET_3)
  ) u_preset (
    .sel_i   (preset_sel_i),
    .value_o (preset_val)
  );

  crc16_bit_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_i     (load_evt),
    .load_i      (accept_evt),
    .data_i      (data_i),
    .msb_first_i (msb_first_i),
    .busy_o      (busy),
    .bit_o       (cur_bit),
    .order_o     (cur_order),
    .last_o      (last_bit)
  );

  crc16_bit_step #(.POLY_FWD(POLY_FWD), .POLY_REV(POLY_REV)) u_step (
    .crc_i       (crc_q),
    .bit_i       (cur_bit),
    .msb_first_i (cur_order),
    .crc_o       (crc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= '0;
    else if (load_evt) crc_q <= preset_val;
    else if (step_evt) crc_q <= crc_next;
  end

  assign busy_o      = busy;
  assign ready_o     = !busy;
  assign result_hi_o = crc_q[CRC_W-1:HALF_W];
  assign result_lo_o = crc_q[HALF_W-1:0];
endmodule

module crc16_engine_chk #(
  parameter int BYTE_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] preset_sel_i,
  input logic       data_valid_i,
  input logic       busy_o,
  input logic       ready_o,
  input logic [7:0] result_hi_o,
  input logic [7:0] result_lo_o,
  input logic       accept_evt,
  input logic       last_bit
);
  logic [15:0] res;
  logic [7:0]  run_q;
  logic [15:0] exp_preset;

  assign res = {result_hi_o, result_lo_o};

  always_comb begin
    case (preset_sel_i)
      2'd0:    exp_preset = 16'h0000;
      2'd1:    exp_preset = 16'h6363;
      2'd2:    exp_preset = 16'hA671;
      default: exp_preset = 16'hFFFF;
    endcase
  end

  // Consecutive busy cycles seen before the current one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= (run_q == 8'hFF) ? run_q : run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r1_ready_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o == !busy_o);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!busy_o && res == $past(exp_preset)));

  a_r6_accept_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy_o && $stable(res)));

  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < 8'(BYTE_W)));

  a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && run_q == 8'(BYTE_W - 1)) |=> !busy_o);

  a_r6_last_matches_run: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> (run_q == 8'(BYTE_W - 1)));

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && run_q < 8'(BYTE_W - 1)) |=> busy_o);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !data_valid_i) |=> ($stable(res) && !busy_o));
endmodule

bind crc16_engine crc16_engine_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .preset_sel_i (preset_sel_i),
  .data_valid_i (data_valid_i),
  .busy_o       (busy_o),
  .ready_o      (ready_o),
  .result_hi_o  (result_hi_o),
  .result_lo_o  (result_lo_o),
  .accept_evt   (accept_evt),
  .last_bit     (last_bit)
);

// File: tb/crc16_engine_bench.sv
`timescale 1ns/1ps
module crc16_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] preset_sel_i = 2'd0;
  logic       msb_first_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       data_valid_i = 1'b0;
  logic       busy_o, ready_o;
  logic [7:0] result_hi_o, result_lo_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  crc16_engine u_crc16_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .preset_sel_i(preset_sel_i),
    .msb_first_i(msb_first_i), .data_i(data_i), .data_valid_i(data_valid_i),
    .busy_o(busy_o), .ready_o(ready_o),
    .result_hi_o(result_hi_o), .result_lo_o(result_lo_o)
  );

  // ---------------- reference arithmetic ----------------
  function automatic int unsigned rev16(input int unsigned v);
    int unsigned r = 0;
    for (int i = 0; i < 16; i++) if ((v >> i) & 1) r |= (1 << (15 - i));
    return r;
  endfunction

  // Long-division step with the full 17-bit generator.
  function automatic int unsigned div_step(input int unsigned s, input int unsigned b);
    int unsigned t = s << 1;
    if ((((s >> 15) & 1) ^ b) != 0) t ^= 32'h11021;
    return t & 32'hFFFF;
  endfunction

  // The reflected order is the forward step applied to a mirrored register.
  function automatic int unsigned ref_bit(input int unsigned c, input int unsigned b, input bit msb);
    if (msb) return div_step(c, b);
    return rev16(div_step(rev16(c), b));
  endfunction

  function automatic int unsigned ref_byte(input int unsigned c, input int unsigned d, input bit msb);
    for (int i = 0; i < 8; i++)
      c = ref_bit(c, msb ? ((d >> (7 - i)) & 1) : ((d >> i) & 1), msb);
    return c;
  endfunction

  function automatic int unsigned preset_of(input int unsigned sel);
    case (sel)
      0: return 32'h0000;
      1: return 32'h6363;
      2: return 32'hA671;
      default: return 32'hFFFF;
    endcase
  endfunction

  // ---------------- cycle model ----------------
  int unsigned m_crc = 0;
  int unsigned m_bits[$];
  bit m_ord = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_crc = 0; m_bits.delete();
    end else if (start_i) begin
      m_crc = preset_of(preset_sel_i); m_bits.delete();
    end else if (m_bits.size() > 0) begin
      m_crc = ref_bit(m_crc, m_bits.pop_front(), m_ord);
    end else if (data_valid_i) begin
      m_ord = msb_first_i;
      for (int i = 0; i < 8; i++)
        m_bits.push_back(msb_first_i ? data_i[7 - i] : data_i[i]);
    end
  end

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en && !finished) begin
      chk("R5 per-cycle result", {result_hi_o, result_lo_o}, m_crc);
      chk("R6 per-cycle busy", busy_o, (m_bits.size() > 0) ? 1 : 0);
      chk("R6 per-cycle ready", ready_o, (m_bits.size() > 0) ? 0 : 1);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic do_start(input int unsigned sel);
    @(negedge clk);
    start_i = 1'b1; preset_sel_i = 2'(sel);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_byte(input int unsigned b, input bit msb);
    wait_idle();
    data_i = 8'(b); msb_first_i = msb; data_valid_i = 1'b1;
    @(negedge clk);
    data_valid_i = 1'b0;
    wait_idle();
  endtask

  task automatic send_check_string(input bit msb);
    string s = "123456789";
    for (int i = 0; i < s.len(); i++) send_byte(s[i], msb);
  endtask

  function automatic int unsigned res();
    return {result_hi_o, result_lo_o};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int unsigned exp, held;
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset result", res(), 32'h0000);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset ready", ready_o, 1);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);

    // R2: each preset code
    for (int s = 0; s < 4; s++) begin
      do_start(s);
      chk("R2 preset load", res(), preset_of(s));
      chk("R2 busy low after start", busy_o, 0);
    end

    // R3 and R5: card preset, reflected order, two zero bytes -> 1EA0h
    do_start(1);
    send_byte(8'h00, 0);
    send_byte(8'h00, 0);
    chk("R3 card check value", res(), 32'h1EA0);
    chk("R5 high byte", result_hi_o, 8'h1E);
    chk("R5 low byte", result_lo_o, 8'hA0);

    // R4: forward order, all-ones preset
    do_start(3);
    send_check_string(1);
    chk("R4 forward check value", res(), 32'h29B1);

    // R3: reflected order, zero preset
    do_start(0);
    send_check_string(0);
    chk("R3 reflected zero-preset value", res(), 32'h2189);

    // R5: no final inversion
    do_start(3);
    send_check_string(0);
    chk("R5 no final xor", res(), 32'h6F91);

    // R6: busy length
    do_start(2);
    wait_idle();
    data_i = 8'h5A; msb_first_i = 1'b1; data_valid_i = 1'b1;
    @(negedge clk);
    data_valid_i = 1'b0;
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R6 busy cycles", n, 8);
    chk("R6 byte result", res(), ref_byte(32'hA671, 8'h5A, 1));

    // R7: valid held during busy with other data is dropped
    do_start(1);
    data_i = 8'h3C; msb_first_i = 1'b0; data_valid_i = 1'b1;
    @(negedge clk);
    data_i = 8'hFF;
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    data_valid_i = 1'b0;
    chk("R7 busy period unchanged", n, 8);
    chk("R7 result unaffected", res(), ref_byte(32'h6363, 8'h3C, 0));

    // R8: start aborts a byte in progress
    do_start(0);
    data_i = 8'hC3; msb_first_i = 1'b0; data_valid_i = 1'b1;
    @(negedge clk);
    data_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    do_start(2);
    chk("R8 abort result", res(), 32'hA671);
    chk("R8 abort busy", busy_o, 0);

    // R8: start and valid together
    @(negedge clk);
    start_i = 1'b1; preset_sel_i = 2'd1; data_valid_i = 1'b1; data_i = 8'h77;
    @(negedge clk);
    start_i = 1'b0; data_valid_i = 1'b0;
    chk("R8 start wins result", res(), 32'h6363);
    chk("R8 start wins busy", busy_o, 0);

    // R9: idle stability
    send_byte(8'h91, 1);
    held = res();
    for (int i = 0; i < 6; i++) begin
      data_i = 8'(i * 37); msb_first_i = i[0];
      @(negedge clk);
    end
    chk("R9 idle hold", res(), held);

    // R10: order sampled at acceptance
    do_start(3);
    data_i = 8'hA5; msb_first_i = 1'b0; data_valid_i = 1'b1;
    @(negedge clk);
    data_valid_i = 1'b0; msb_first_i = 1'b1;
    wait_idle();
    chk("R10 order latched", res(), ref_byte(32'hFFFF, 8'hA5, 0));

    // Mixed stream, compared every cycle against the model
    exp = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      start_i = ($urandom_range(0, 29) == 0);
      preset_sel_i = 2'($urandom_range(0, 3));
      data_valid_i = ($urandom_range(0, 2) != 0);
      data_i = 8'($urandom);
      msb_first_i = 1'($urandom);
    end
    @(negedge clk);
    start_i = 0; data_valid_i = 0;
    wait_idle();
    @(negedge clk);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule